// File: doc/BRIEF.md
# Security-Banked Interrupt Controller Register File

This block holds the software-visible register state of a nested interrupt controller in a processor that runs in a secure and a non-secure state. Each state owns a complete, independent copy of the per-interrupt enable, pending, active and priority registers. Both copies answer at one shared register page, and the security flag of each bus access picks the copy that responds. Software in either state therefore uses the same offsets and the same driver code.

The secure state also reaches the non-secure copy through a second page, the alias window, which lies in a separate alias region of the system control space. A non-secure access to that window reads zero and its writes are dropped. A secure-only array of target words assigns each interrupt to one of the two states. That assignment decides which copy an incoming interrupt pulse marks pending. It also decides which copy drives the per-interrupt enable, pending and priority outputs towards the prioritisation logic, which sits outside this block.

Accesses are single 32-bit words. Address bits [1:0] are ignored. A read returns its data one cycle after the read strobe.

Top module: `sbirq_regs`

## Requirements
- R1: An access to the shared page (SCS_BASE+0x100 up to +0x3FF) reaches the secure copy when sec_i=1 and the non-secure copy when sec_i=0. Page offsets are: 0x000 set-enable, 0x080 clear-enable, 0x100 set-pending, 0x180 clear-pending, 0x200 active, 0x280 target words, 0x300 priority bytes. Each word is 4 bytes, and bit j of word w stands for interrupt 32*w+j.
- R2: A secure access to the alias page (ALIAS_BASE+0x100 up to +0x3FF) reads and writes the non-secure copy at the same offsets and leaves the secure copy unchanged.
- R3: A non-secure access to the alias page reads zero and changes no state.
- R4: Target word w (page offset 0x280+4*w) is read and written whole by secure accesses to the shared page only. Bit j set means interrupt 32*w+j targets the non-secure state. Non-secure accesses read zero and do not write. Words at or above NUM_IRQ/32 read zero and ignore writes.
- R5: Writing a set or clear register changes only the bits written as one; zero bits leave state unchanged. Reading either register of a pair returns the current state.
- R6: Priority byte b of word p (offset 0x300+4*p) belongs to interrupt 4*p+b at bits [8b+7:8b]. Only the upper PRIO_W bits of each byte are stored, and the lower bits read as zero.
- R7: The active register of a copy shows irq_act_i for the interrupts that target that copy, reads zero for all others, and ignores writes.
- R8: A one-cycle irq_pulse_i bit sets the pending bit of that interrupt in the copy its target bit selects. A pulse takes priority over a clear-pending write in the same cycle.
- R9: irq_en_o, irq_pend_o and irq_prio_o for each interrupt come from the copy its target bit selects. irq_ns_o shows the target bits.
- R10: Reset clears all enables, pending bits, priorities and target bits, so every interrupt starts out targeting the secure state.
- R11: rdata_o carries the data for the access presented with rd_en_i in the previous cycle and is zero otherwise. Addresses outside both pages, and words beyond the implemented interrupts, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| sec_i | input | 1 | 1 for a secure access, 0 for a non-secure access |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_pulse_i | input | NUM_IRQ | One-cycle pending requests, one per interrupt |
| irq_act_i | input | NUM_IRQ | Active flags supplied by the core |
| irq_en_o | output | NUM_IRQ | Enable of each interrupt from its selected copy |
| irq_pend_o | output | NUM_IRQ | Pending of each interrupt from its selected copy |
| irq_prio_o | output | NUM_IRQ*PRIO_W | Stored priority bits, interrupt i at [i*PRIO_W +: PRIO_W] |
| irq_ns_o | output | NUM_IRQ | Target bit of each interrupt (1 = non-secure) |

## Verification
The bench builds the block with NUM_IRQ=64 and PRIO_W=3. With two words per register array, it can reach the last implemented word, the first unimplemented word and an unimplemented target word. The 3-bit priority width makes the zeroed low bits of each priority byte visible. Interrupts 0 to 3 are moved to the non-secure state while 4 to 7 stay secure, so a single output byte mixes bits from both copies.

// File: rtl/sbirq_pkg.sv
package sbirq_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        K_SETEN = 3'd0,
        K_CLREN = 3'd1,
        K_SETPD = 3'd2,
        K_CLRPD = 3'd3,
        K_ACT   = 3'd4,
        K_TGT   = 3'd5,
        K_PRIO  = 3'd6,
        K_NONE  = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic      hit_s;
        logic      hit_ns;
        logic      tgt_ok;
        reg_kind_e kind;
        logic [5:0] widx;
    } acc_dec_t;

endpackage

// File: rtl/sbirq_decode.sv
module sbirq_decode
    import sbirq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] SCS_BASE   = 32'h0000_E000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h0002_E000,
    parameter logic [ADDR_W-1:0] PAGE_OFF   = 32'h0000_0100
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sec_i,
    output acc_dec_t          dec_o
);
    localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(1024);
    localparam logic [ADDR_W-1:0] P_BASE = SCS_BASE + PAGE_OFF;
    localparam logic [ADDR_W-1:0] A_BASE = ALIAS_BASE + PAGE_OFF;

    logic [ADDR_W-1:0] off_p, off_a;
    logic              in_p, in_a;
    logic [9:0]        off;

    always_comb begin
        off_p = addr_i - P_BASE;
        off_a = addr_i - A_BASE;
        in_p  = off_p < SPAN;
        in_a  = off_a < SPAN;
        off   = in_p ? off_p[9:0] : off_a[9:0];
        dec_o = '0;
        case (off[9:7])
            3'd0:    dec_o.kind = K_SETEN;
            3'd1:    dec_o.kind = K_CLREN;
            3'd2:    dec_o.kind = K_SETPD;
            3'd3:    dec_o.kind = K_CLRPD;
            3'd4:    dec_o.kind = K_ACT;
            3'd5:    dec_o.kind = K_TGT;
            default: dec_o.kind = K_PRIO;
        endcase
        dec_o.widx   = (dec_o.kind == K_PRIO) ? off[7:2] : {1'b0, off[6:2]};
        dec_o.hit_s  = in_p & sec_i;
        dec_o.hit_ns = (in_p & ~sec_i) | (in_a & sec_i);
        dec_o.tgt_ok = in_p & sec_i & (dec_o.kind == K_TGT);
    end
endmodule

// File: rtl/sbirq_copy.sv
module sbirq_copy
    import sbirq_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 3
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_i,
    input  reg_kind_e                 kind_i,
    input  logic [5:0]                widx_i,
    input  logic [WORD_W-1:0]         wdata_i,
    input  logic [NUM_IRQ-1:0]        set_pend_i,
    input  logic [NUM_IRQ-1:0]        act_i,
    output logic [NUM_IRQ-1:0]        en_o,
    output logic [NUM_IRQ-1:0]        pend_o,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_o,
    output logic [WORD_W-1:0]         rdata_o
);
    localparam int NW  = NUM_IRQ / 32;
    localparam int NPW = NUM_IRQ / 4;
    localparam int LSB = 8 - PRIO_W;

    typedef struct packed {
        logic [NUM_IRQ-1:0]             en;
        logic [NUM_IRQ-1:0]             pend;
        logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
    } copy_st_t;

    copy_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        for (int w = 0; w < NW; w++) begin
            if (widx_i == 6'(w)) begin
                if (wr_i) begin
                    case (kind_i)
                        K_SETEN: st_d.en[w*32 +: 32]   = st_q.en[w*32 +: 32] | wdata_i;
                        K_CLREN: st_d.en[w*32 +: 32]   = st_q.en[w*32 +: 32] & ~wdata_i;
                        K_SETPD: st_d.pend[w*32 +: 32] = st_q.pend[w*32 +: 32] | wdata_i;
                        K_CLRPD: st_d.pend[w*32 +: 32] = st_q.pend[w*32 +: 32] & ~wdata_i;
                        default: ;
                    endcase
                end
                case (kind_i)
                    K_SETEN, K_CLREN: rdata_o = st_q.en[w*32 +: 32];
                    K_SETPD, K_CLRPD: rdata_o = st_q.pend[w*32 +: 32];
                    K_ACT:            rdata_o = act_i[w*32 +: 32];
                    default: ;
                endcase
            end
        end
        if (kind_i == K_PRIO) begin
            for (int p = 0; p < NPW; p++) begin
                if (widx_i == 6'(p)) begin
                    for (int b = 0; b < 4; b++) begin
                        if (wr_i) st_d.prio[p*4+b] = wdata_i[8*b+LSB +: PRIO_W];
                        rdata_o[8*b+LSB +: PRIO_W] = st_q.prio[p*4+b];
                    end
                end
            end
        end
        // an incoming pulse is applied last, so it wins over a clear
        st_d.pend = st_d.pend | set_pend_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign prio_o = st_q.prio;
endmodule

// File: rtl/sbirq_target.sv
module sbirq_target
    import sbirq_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [5:0]         widx_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [NUM_IRQ-1:0] ns_o,
    output logic [WORD_W-1:0]  rdata_o
);
    localparam int NW = NUM_IRQ / 32;

    typedef struct packed {
        logic [NUM_IRQ-1:0] ns;
    } tgt_st_t;

    tgt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        for (int w = 0; w < NW; w++) begin
            if (widx_i == 6'(w)) begin
                rdata_o = st_q.ns[w*32 +: 32];
                if (wr_i) st_d.ns[w*32 +: 32] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ns_o = st_q.ns;
endmodule

// File: rtl/sbirq_regs.sv
module sbirq_regs
    import sbirq_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] SCS_BASE   = 32'h0000_E000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h0002_E000,
    parameter logic [ADDR_W-1:0] PAGE_OFF   = 32'h0000_0100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [31:0]               wdata_i,
    input  logic                      wr_en_i,
    input  logic                      rd_en_i,
    input  logic                      sec_i,
    output logic [31:0]               rdata_o,
    input  logic [NUM_IRQ-1:0]        irq_pulse_i,
    input  logic [NUM_IRQ-1:0]        irq_act_i,
    output logic [NUM_IRQ-1:0]        irq_en_o,
    output logic [NUM_IRQ-1:0]        irq_pend_o,
    output logic [NUM_IRQ*PRIO_W-1:0] irq_prio_o,
    output logic [NUM_IRQ-1:0]        irq_ns_o
);
    localparam int NCOPY = 2;

    typedef struct packed {
        logic [31:0] rdata;
    } rd_st_t;

    acc_dec_t                  dec;
    logic [NUM_IRQ-1:0]        tgt_ns;
    logic [31:0]               tgt_rd;
    logic [NUM_IRQ-1:0]        c_en [NCOPY];
    logic [NUM_IRQ-1:0]        c_pd [NCOPY];
    logic [NUM_IRQ*PRIO_W-1:0] c_pr [NCOPY];
    logic [31:0]               c_rd [NCOPY];
    rd_st_t                    rd_d, rd_q;

    sbirq_decode #(
        .ADDR_W(ADDR_W), .SCS_BASE(SCS_BASE), .ALIAS_BASE(ALIAS_BASE), .PAGE_OFF(PAGE_OFF)
    ) u_dec (
        .addr_i(addr_i), .sec_i(sec_i), .dec_o(dec)
    );

    sbirq_target #(.NUM_IRQ(NUM_IRQ)) u_tgt (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_i(wr_en_i & dec.tgt_ok), .widx_i(dec.widx), .wdata_i(wdata_i),
        .ns_o(tgt_ns), .rdata_o(tgt_rd)
    );

    // copy 0 serves the secure state, copy 1 the non-secure state
    for (genvar b = 0; b < NCOPY; b++) begin : g_copy
        logic               sel;
        logic [NUM_IRQ-1:0] mine;
        assign sel  = (b == 0) ? dec.hit_s : dec.hit_ns;
        assign mine = (b == 0) ? ~tgt_ns : tgt_ns;
        sbirq_copy #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_copy (
            .clk_i(clk), .rst_ni(rst_n),
            .wr_i(wr_en_i & sel), .kind_i(dec.kind), .widx_i(dec.widx), .wdata_i(wdata_i),
            .set_pend_i(irq_pulse_i & mine), .act_i(irq_act_i & mine),
            .en_o(c_en[b]), .pend_o(c_pd[b]), .prio_o(c_pr[b]), .rdata_o(c_rd[b])
        );
    end

    always_comb begin
        rd_d = '0;
        if (rd_en_i) begin
            if (dec.tgt_ok)      rd_d.rdata = tgt_rd;
            else if (dec.hit_s)  rd_d.rdata = c_rd[0];
            else if (dec.hit_ns) rd_d.rdata = c_rd[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            irq_en_o[i]   = tgt_ns[i] ? c_en[1][i] : c_en[0][i];
            irq_pend_o[i] = tgt_ns[i] ? c_pd[1][i] : c_pd[0][i];
            irq_prio_o[i*PRIO_W +: PRIO_W] = tgt_ns[i] ? c_pr[1][i*PRIO_W +: PRIO_W]
                                                       : c_pr[0][i*PRIO_W +: PRIO_W];
        end
    end

    assign irq_ns_o = tgt_ns;
    assign rdata_o  = rd_q.rdata;
endmodule

// File: rtl/sbirq_regs_chk.sv
module sbirq_regs_chk #(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h0002_E000,
    parameter logic [ADDR_W-1:0] PAGE_OFF   = 32'h0000_0100
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               wr_en_i,
    input logic               rd_en_i,
    input logic               sec_i,
    input logic [31:0]        rdata_o,
    input logic [NUM_IRQ-1:0] irq_pulse_i,
    input logic [NUM_IRQ-1:0] irq_en_o,
    input logic [NUM_IRQ-1:0] irq_pend_o,
    input logic [NUM_IRQ-1:0] irq_ns_o
);
    localparam logic [ADDR_W-1:0] A_BASE = ALIAS_BASE + PAGE_OFF;
    logic [ADDR_W-1:0] a_off;
    assign a_off = addr_i - A_BASE;

    p_ns_tgt_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !sec_i) |=> $stable(irq_ns_o));

    p_alias_raz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !sec_i && (a_off < ADDR_W'(1024))) |=> (rdata_o == 32'h0));

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rdata_o == 32'h0));

    p_pulse_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|irq_pulse_i) && !wr_en_i) |=> ((irq_pend_o & $past(irq_pulse_i)) == $past(irq_pulse_i)));

    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(irq_en_o));
endmodule

bind sbirq_regs sbirq_regs_chk #(
    .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .ALIAS_BASE(ALIAS_BASE), .PAGE_OFF(PAGE_OFF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .sec_i(sec_i), .rdata_o(rdata_o), .irq_pulse_i(irq_pulse_i), .irq_en_o(irq_en_o),
    .irq_pend_o(irq_pend_o), .irq_ns_o(irq_ns_o)
);

// File: tb/sbirq_regs_bench.sv
module sbirq_regs_bench;
    localparam int NUM_IRQ = 64;
    localparam int PRIO_W  = 3;
    localparam int NW      = NUM_IRQ / 32;
    localparam logic [31:0] SB = 32'h0000_E100;
    localparam logic [31:0] AB = 32'h0002_E100;
    localparam logic [7:0]  PMASK = 8'hFF << (8 - PRIO_W);

    logic clk = 0, rst_n = 0;
    logic [31:0] addr_i = 0, wdata_i = 0, rdata_o;
    logic wr_en_i = 0, rd_en_i = 0, sec_i = 0;
    logic [NUM_IRQ-1:0] irq_pulse_i = 0, irq_act_i = 0, irq_en_o, irq_pend_o, irq_ns_o;
    logic [NUM_IRQ*PRIO_W-1:0] irq_prio_o;

    int total = 0, bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    sbirq_regs #(
        .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(32),
        .SCS_BASE(32'h0000_E000), .ALIAS_BASE(32'h0002_E000), .PAGE_OFF(32'h0000_0100)
    ) u_sbirq_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .sec_i(sec_i), .rdata_o(rdata_o), .irq_pulse_i(irq_pulse_i),
        .irq_act_i(irq_act_i), .irq_en_o(irq_en_o), .irq_pend_o(irq_pend_o),
        .irq_prio_o(irq_prio_o), .irq_ns_o(irq_ns_o)
    );

    // behavioural reference: copy index 0 = secure, 1 = non-secure
    bit       m_en [2][NUM_IRQ];
    bit       m_pd [2][NUM_IRQ];
    bit [7:0] m_pr [2][NUM_IRQ];
    bit       m_tg [NUM_IRQ];
    logic [31:0] m_rd = 0;

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // returns the copy an access reaches, -1 for none; off gets the page offset
    function automatic int route(input logic [31:0] a, input bit s, output int off, output bit prim);
        prim = 0; off = 0;
        if (a >= SB && a < SB + 1024) begin off = int'(a - SB); prim = 1; return s ? 0 : 1; end
        if (a >= AB && a < AB + 1024) begin off = int'(a - AB); return s ? 1 : -1; end
        return -1;
    endfunction

    function automatic logic [31:0] mread(input logic [31:0] a, input bit s);
        logic [31:0] r = 0;
        int off, bk, k, w, pw;
        bit prim;
        bk = route(a, s, off, prim);
        if (bk < 0) return 0;
        k = off / 128; w = (off % 128) / 4; pw = (off - 768) / 4;
        for (int j = 0; j < 32; j++) begin
            case (k)
                0, 1: if (w < NW) r[j] = m_en[bk][w*32+j];
                2, 3: if (w < NW) r[j] = m_pd[bk][w*32+j];
                4:    if (w < NW) r[j] = irq_act_i[w*32+j] && (int'(m_tg[w*32+j]) == bk);
                5:    if (w < NW && prim && s) r[j] = m_tg[w*32+j];
                default: if (pw < NUM_IRQ / 4) r[j] = m_pr[bk][pw*4 + j/8][j%8];
            endcase
        end
        return r;
    endfunction

    task automatic mwrite(input logic [31:0] a, input logic [31:0] d, input bit s);
        int off, bk, k, w, pw;
        bit prim;
        bk = route(a, s, off, prim);
        if (bk < 0) return;
        k = off / 128; w = (off % 128) / 4; pw = (off - 768) / 4;
        if (k >= 6) begin
            if (pw < NUM_IRQ / 4)
                for (int b = 0; b < 4; b++) m_pr[bk][pw*4+b] = d[8*b +: 8] & PMASK;
            return;
        end
        if (w >= NW) return;
        for (int j = 0; j < 32; j++) begin
            case (k)
                0: if (d[j]) m_en[bk][w*32+j] = 1;
                1: if (d[j]) m_en[bk][w*32+j] = 0;
                2: if (d[j]) m_pd[bk][w*32+j] = 1;
                3: if (d[j]) m_pd[bk][w*32+j] = 0;
                5: if (prim && s) m_tg[w*32+j] = d[j];
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        bit tg_old [NUM_IRQ];
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                m_tg[i] = 0;
                for (int b = 0; b < 2; b++) begin m_en[b][i] = 0; m_pd[b][i] = 0; m_pr[b][i] = 0; end
            end
            m_rd = 0;
        end else begin
            m_rd = rd_en_i ? mread(addr_i, sec_i) : 32'h0;
            tg_old = m_tg;
            if (wr_en_i) mwrite(addr_i, wdata_i, sec_i);
            for (int i = 0; i < NUM_IRQ; i++)
                if (irq_pulse_i[i]) m_pd[tg_old[i]][i] = 1;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        logic [NUM_IRQ-1:0] e_en, e_pd, e_tg;
        logic [NUM_IRQ*PRIO_W-1:0] e_pr;
        for (int i = 0; i < NUM_IRQ; i++) begin
            e_en[i] = m_en[m_tg[i]][i];
            e_pd[i] = m_pd[m_tg[i]][i];
            e_tg[i] = m_tg[i];
            e_pr[i*PRIO_W +: PRIO_W] = m_pr[m_tg[i]][i][7 -: PRIO_W];
        end
        check("R9 model irq_en_o", 256'(irq_en_o), 256'(e_en));
        check("R8 model irq_pend_o", 256'(irq_pend_o), 256'(e_pd));
        check("R6 model irq_prio_o", 256'(irq_prio_o), 256'(e_pr));
        check("R4 model irq_ns_o", 256'(irq_ns_o), 256'(e_tg));
        check("R11 model rdata_o", 256'(rdata_o), 256'(m_rd));
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit s);
        addr_i = a; wdata_i = d; sec_i = s; wr_en_i = 1;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic rd(input logic [31:0] a, input bit s, input logic [31:0] exp, input string tag);
        addr_i = a; sec_i = s; rd_en_i = 1;
        @(negedge clk);
        rd_en_i = 0;
        check(tag, 256'(rdata_o), 256'(exp));
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: everything clear after reset
        check("R10 irq_en_o", 256'(irq_en_o), 256'(0));
        check("R10 irq_ns_o", 256'(irq_ns_o), 256'(0));
        rd(SB + 32'h000, 1, 32'h0, "R10 secure enable");
        rd(SB + 32'h300, 0, 32'h0, "R10 priority");

        // R1: one address, two copies
        wr(SB + 32'h000, 32'h0000_00F0, 1);
        wr(SB + 32'h000, 32'h0000_000F, 0);
        rd(SB + 32'h000, 1, 32'h0000_00F0, "R1 secure copy");
        rd(SB + 32'h080, 0, 32'h0000_000F, "R1 R5 non-secure copy via clear reg");

        // R2: secure alias reaches only the non-secure copy
        wr(AB + 32'h004, 32'h8000_0001, 1);
        rd(SB + 32'h004, 0, 32'h8000_0001, "R2 alias write seen by non-secure");
        rd(SB + 32'h004, 1, 32'h0, "R2 secure copy untouched");

        // R3: non-secure alias is read-as-zero, write-ignored
        wr(AB + 32'h080, 32'hFFFF_FFFF, 0);
        rd(AB + 32'h000, 0, 32'h0, "R3 non-secure alias read");
        rd(AB + 32'h000, 1, 32'h0000_000F, "R3 non-secure copy kept");

        // R4: target words
        wr(SB + 32'h280, 32'h0000_FFFF, 0);
        rd(SB + 32'h280, 1, 32'h0, "R4 non-secure write dropped");
        wr(SB + 32'h280, 32'h0000_000F, 1);
        rd(SB + 32'h280, 1, 32'h0000_000F, "R4 secure target write");
        rd(SB + 32'h280, 0, 32'h0, "R4 non-secure target read");
        wr(SB + 32'h294, 32'hFFFF_FFFF, 1);
        rd(SB + 32'h294, 1, 32'h0, "R4 unimplemented target word");
        check("R9 mixed enable byte", 256'(irq_en_o[7:0]), 256'(8'hFF));

        // R5: set/clear act on one bits only
        wr(SB + 32'h080, 32'h0000_0030, 1);
        wr(SB + 32'h000, 32'h0, 1);
        rd(SB + 32'h000, 1, 32'h0000_00C0, "R5 enable after clear");
        check("R9 enable byte after clear", 256'(irq_en_o[7:0]), 256'(8'hCF));
        wr(SB + 32'h100, 32'h0000_0101, 1);
        wr(SB + 32'h180, 32'h0000_0001, 1);
        rd(SB + 32'h180, 1, 32'h0000_0100, "R5 pending pair");

        // R6: priority bytes keep the upper PRIO_W bits
        wr(SB + 32'h300, 32'hFFEE_1234, 1);
        rd(SB + 32'h300, 1, 32'hE0E0_0020, "R6 secure priority word");
        wr(AB + 32'h300, 32'h0000_0080, 1);
        rd(SB + 32'h300, 0, 32'h0000_0080, "R6 non-secure priority word");
        check("R9 priority of irq0", 256'(irq_prio_o[PRIO_W-1:0]), 256'(4));

        // R7: active split by target, read-only
        irq_act_i = 64'h11;
        rd(SB + 32'h200, 1, 32'h0000_0010, "R7 secure active");
        rd(SB + 32'h200, 0, 32'h0000_0001, "R7 non-secure active");
        wr(SB + 32'h200, 32'hFFFF_FFFF, 1);
        rd(SB + 32'h200, 1, 32'h0000_0010, "R7 active write ignored");
        irq_act_i = 0;

        // R8: pulses route by target; pulse beats clear
        irq_pulse_i = 64'h42;
        @(negedge clk);
        irq_pulse_i = 0;
        rd(SB + 32'h100, 0, 32'h0000_0002, "R8 non-secure pulse");
        rd(SB + 32'h100, 1, 32'h0000_0140, "R8 secure pulse");
        irq_pulse_i = 64'h100;
        wr(SB + 32'h180, 32'h0000_0100, 1);
        irq_pulse_i = 0;
        rd(SB + 32'h100, 1, 32'h0000_0140, "R8 pulse wins over clear");

        // R11: outside windows and beyond implemented words
        rd(32'h0000_0000, 1, 32'h0, "R11 outside window");
        rd(SB + 32'h400, 1, 32'h0, "R11 past page end");
        rd(SB + 32'h008, 1, 32'h0, "R11 unimplemented enable word");
        @(negedge clk);
        check("R11 idle rdata", 256'(rdata_o), 256'(0));

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule